// File: doc/BRIEF.md
# Configuration Memory Security Controller

This block guards a nonvolatile configuration store made of a pattern array and a signature word. A programmer interface issues one command at a time through a valid/ready handshake. The commands write a pattern word, read a pattern word, set the security lock, bulk-erase the device, read a signature chunk and write a signature chunk. Once the lock is set, the pattern can no longer be read back or rewritten. The signature can still be written only while the device is unlocked. The lock can be cleared only by an erase of the whole device. The signature stays readable at all times, so a locked part can still show which design and revision it holds.

The signature is `SIG_W` bits wide, either 24 or 64. It is reached in `DATA_W`-bit chunks, and the chunk index is carried on the address field. Reads answer on the cycle after they are accepted. Writes, lock and erase commands hold `busy` for a fixed `BUSY_CYC` cycles and then give a completion response. The storage cells are plain registers. A reset returns them to the erased state, so it stands in for a fresh, blank device.

Top module: `cfgsec_ctrl`

## Requirements
- R1: Once reset has been released, `cmd_ready` is 1 and `busy`, `locked` and `rsp_valid` are 0. Every pattern word reads as all ones and every signature chunk reads as all ones.
- R2: A command is taken on a rising edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` stays low in every cycle where `busy` is high.
- R3: A read (`cmd_op`=1) on an unlocked device raises `rsp_valid` for one cycle, on the cycle after acceptance. `rsp_err` is 0 and `rsp_data` holds the pattern word at `cmd_addr`.
- R4: A write (`cmd_op`=0) on an unlocked device holds `busy` high for exactly `BUSY_CYC` cycles. On the edge where `busy` falls, `rsp_valid` pulses with `rsp_err`=0. From then on, the word at `cmd_addr` holds `cmd_wdata`, and no other word has changed.
- R5: A lock command (`cmd_op`=2) holds `busy` for `BUSY_CYC` cycles and sets `locked` at completion. The stored contents do not change.
- R6: A write that is accepted with `cmd_seal`=1 sets `locked` at its completion, on the same edge that the write takes effect.
- R7: While `locked` is 1, a read, a write or a signature write is refused. The response comes on the cycle after acceptance with `rsp_err`=1 and `rsp_data`=0, `busy` is never raised, and the stored contents are left unchanged.
- R8: An erase (`cmd_op`=3) holds `busy` for `BUSY_CYC` cycles. At completion it sets every pattern bit and every signature bit to 1 and clears `locked`. No other command clears `locked`.
- R9: A signature read (`cmd_op`=4) with chunk index `cmd_addr` below `SIG_W/DATA_W` answers on the cycle after acceptance with `rsp_err`=0. `rsp_data` holds signature bits [`cmd_addr`*`DATA_W` +: `DATA_W`]. This holds whether or not the device is locked.
- R10: A signature write (`cmd_op`=5) on an unlocked device with a chunk index in range behaves like R4, but it replaces the selected signature chunk.
- R11: The operation codes 6 and 7 are refused, and so is a signature read or write whose chunk index is not below `SIG_W/DATA_W`. A refusal gives `rsp_err`=1 and `rsp_data`=0 on the cycle after acceptance.
- R12: A lock command issued while `locked` is already 1 is accepted without error, and `locked` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | Operation code: 0 write, 1 read, 2 lock, 3 erase, 4 signature read, 5 signature write |
| cmd_addr | input | ADDR_W | Pattern word address, or signature chunk index |
| cmd_wdata | input | DATA_W | Write data |
| cmd_seal | input | 1 | With a write, set the lock when the write completes |
| busy | output | 1 | A write, lock or erase operation is in progress |
| locked | output | 1 | Security lock state |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Command refused; valid with rsp_valid |
| rsp_data | output | DATA_W | Read data; zero when the command is refused or has no data |

## Verification
The assertions assume that `cmd_op`, `cmd_addr`, `cmd_wdata` and `cmd_seal` stay steady while `cmd_valid` waits for `cmd_ready`. They also assume that the programmer never needs to apply backpressure to a response. The bench drives every input on the falling edge and holds it until it sees acceptance. It issues the next command only after the previous response has been observed, so no command ever overlaps an operation still in progress. Each chunk index the bench uses falls either clearly inside or clearly outside the signature range, because the refusal it expects depends on where the index lies.

// File: rtl/cfgsec_pkg.sv
package cfgsec_pkg;
  typedef logic [2:0] op_t;
  localparam op_t OP_PROG    = 3'd0;
  localparam op_t OP_READ    = 3'd1;
  localparam op_t OP_SECURE  = 3'd2;
  localparam op_t OP_ERASE   = 3'd3;
  localparam op_t OP_SIGRD   = 3'd4;
  localparam op_t OP_SIGPROG = 3'd5;
endpackage

// File: rtl/cfgsec_rstsync.sv
module cfgsec_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/cfgsec_store.sv
module cfgsec_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SIG_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  input  logic [ADDR_W-1:0] sig_idx,
  output logic [DATA_W-1:0] sig_word,
  input  logic              we_word,
  input  logic              we_sig,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase,
  input  logic              set_lock,
  output logic              locked
);
  localparam int WORDS  = 1 << ADDR_W;
  localparam int CHUNKS = SIG_W / DATA_W;

  logic [DATA_W-1:0] pat_q [WORDS];
  logic [DATA_W-1:0] sig_q [CHUNKS];
  logic              lock_q;

  // pattern array: erase forces all ones, otherwise one addressed word is written
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic              en;
    logic [DATA_W-1:0] d;
    assign en = erase || (we_word && (wr_addr == ADDR_W'(w)));
    assign d  = erase ? '1 : wr_data;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pat_q[w] <= '1;
      else if (en) pat_q[w] <= d;
    end
  end

  // signature chunks
  for (genvar c = 0; c < CHUNKS; c++) begin : g_sig
    logic              en;
    logic [DATA_W-1:0] d;
    assign en = erase || (we_sig && (wr_addr == ADDR_W'(c)));
    assign d  = erase ? '1 : wr_data;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sig_q[c] <= '1;
      else if (en) sig_q[c] <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= 1'b0;
    else if (erase)    lock_q <= 1'b0;
    else if (set_lock) lock_q <= 1'b1;
  end

  assign rd_word = pat_q[rd_addr];
  assign locked  = lock_q;

  always_comb begin
    sig_word = '1;
    for (int c = 0; c < CHUNKS; c++) begin
      if (sig_idx == ADDR_W'(c)) sig_word = sig_q[c];
    end
  end
endmodule

// File: rtl/cfgsec_seq.sv
module cfgsec_seq
  import cfgsec_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int SIG_W    = 24,
  parameter int BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  op_t               cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_seal,
  input  logic              locked,
  input  logic [DATA_W-1:0] pat_rd,
  input  logic [DATA_W-1:0] sig_rd,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data,
  output logic              we_word,
  output logic              we_sig,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              erase,
  output logic              set_lock
);
  localparam int CHUNKS = SIG_W / DATA_W;
  localparam int CNT_W  = $clog2(BUSY_CYC + 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  op_t               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              seal_q;
  logic              rv_q, rv_d, re_q, re_d;
  logic [DATA_W-1:0] rd_q, rd_d;

  logic accept, commit, sig_ok, start, refuse;

  assign cmd_ready = rst_n && !busy_q;
  assign accept    = cmd_valid && cmd_ready;
  assign commit    = busy_q && (cnt_q == '0);
  assign sig_ok    = ({1'b0, cmd_addr} < (ADDR_W+1)'(CHUNKS));

  // next state
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    rv_d   = 1'b0;
    re_d   = 1'b0;
    rd_d   = '0;
    start  = 1'b0;
    refuse = 1'b0;
    if (busy_q) begin
      if (commit) begin
        busy_d = 1'b0;
        rv_d   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (accept) begin
      unique case (cmd_op)
        OP_READ:    if (locked) refuse = 1'b1;
                    else begin rv_d = 1'b1; rd_d = pat_rd; end
        OP_PROG:    if (locked) refuse = 1'b1; else start = 1'b1;
        OP_SECURE:  start = 1'b1;
        OP_ERASE:   start = 1'b1;
        OP_SIGRD:   if (!sig_ok) refuse = 1'b1;
                    else begin rv_d = 1'b1; rd_d = sig_rd; end
        OP_SIGPROG: if (locked || !sig_ok) refuse = 1'b1; else start = 1'b1;
        default:    refuse = 1'b1;
      endcase
      if (refuse) begin
        rv_d = 1'b1;
        re_d = 1'b1;
      end
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = CNT_W'(BUSY_CYC - 1);
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rv_q   <= 1'b0;
      re_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      rv_q   <= rv_d;
      re_q   <= re_d;
      rd_q   <= rd_d;
    end
  end

  // held operation, enabled only when an operation starts
  always_ff @(posedge clk) begin
    if (start) begin
      op_q   <= cmd_op;
      addr_q <= cmd_addr;
      data_q <= cmd_wdata;
      seal_q <= cmd_seal;
    end
  end

  assign busy      = busy_q;
  assign rsp_valid = rv_q;
  assign rsp_err   = re_q;
  assign rsp_data  = rd_q;
  assign we_word   = commit && (op_q == OP_PROG);
  assign we_sig    = commit && (op_q == OP_SIGPROG);
  assign erase     = commit && (op_q == OP_ERASE);
  assign set_lock  = commit && ((op_q == OP_SECURE) || ((op_q == OP_PROG) && seal_q));
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
endmodule

// File: rtl/cfgsec_ctrl.sv
module cfgsec_ctrl #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int SIG_W    = 24,
  parameter int BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_seal,
  output logic              busy,
  output logic              locked,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data
);
  logic              rst_n_sync;
  logic [DATA_W-1:0] pat_rd, sig_rd, wr_data;
  logic [ADDR_W-1:0] wr_addr;
  logic              we_word, we_sig, erase, set_lock;

  cfgsec_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cfgsec_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_W(SIG_W), .BUSY_CYC(BUSY_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_seal  (cmd_seal),
    .locked    (locked),
    .pat_rd    (pat_rd),
    .sig_rd    (sig_rd),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data),
    .we_word   (we_word),
    .we_sig    (we_sig),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .erase     (erase),
    .set_lock  (set_lock)
  );

  cfgsec_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_W(SIG_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .rd_addr  (cmd_addr),
    .rd_word  (pat_rd),
    .sig_idx  (cmd_addr),
    .sig_word (sig_rd),
    .we_word  (we_word),
    .we_sig   (we_sig),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .erase    (erase),
    .set_lock (set_lock),
    .locked   (locked)
  );
endmodule

// File: rtl/cfgsec_chk.sv
module cfgsec_chk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int SIG_W    = 24,
  parameter int BUSY_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              busy,
  input logic              locked,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_data
);
  import cfgsec_pkg::*;
  localparam int CHUNKS = SIG_W / DATA_W;

  op_t               acc_op;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_locked;
  logic [15:0]       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_op     <= OP_PROG;
      acc_addr   <= '0;
      acc_locked <= 1'b0;
      run        <= '0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        acc_op     <= cmd_op;
        acc_addr   <= cmd_addr;
        acc_locked <= locked;
      end
      run <= busy ? run + 16'd1 : 16'd0;
    end
  end

  p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < 16'(BUSY_CYC)));
  p_done_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rsp_valid && !rsp_err));
  p_refuse_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && acc_locked &&
     (acc_op == OP_READ || acc_op == OP_PROG || acc_op == OP_SIGPROG)) |-> rsp_err);
  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_data == '0));
  p_unlock_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (rsp_valid && acc_op == OP_ERASE));
  p_sig_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && acc_op == OP_SIGRD && ({1'b0, acc_addr} < (ADDR_W+1)'(CHUNKS))) |-> !rsp_err);
  p_relock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && acc_op == OP_SECURE) |-> (locked && !rsp_err));
endmodule

bind cfgsec_ctrl cfgsec_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_W(SIG_W), .BUSY_CYC(BUSY_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_addr  (cmd_addr),
  .busy      (busy),
  .locked    (locked),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_data  (rsp_data)
);

// File: tb/cfgsec_ctrl_tb.sv
module cfgsec_ctrl_tb;
  localparam int BC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [3:0] cmd_addr = 4'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic       cmd_seal = 1'b0;
  logic       busy, locked, rsp_valid, rsp_err;
  logic [7:0] rsp_data;

  int errors = 0;
  int checks = 0;
  int ready_bad = 0;

  always #2 clk = ~clk;

  cfgsec_ctrl #(.ADDR_W(4), .DATA_W(8), .SIG_W(24), .BUSY_CYC(BC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_seal(cmd_seal),
    .busy(busy), .locked(locked), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_data(rsp_data)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [3:0] a, input logic [7:0] d,
                        input logic s, output logic e, output logic [7:0] q, output int nb);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_seal = s;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_seal = 1'b0;
    nb = 0;
    for (int k = 0; k < 50 && !rsp_valid; k++) begin
      if (busy) begin
        nb++;
        if (cmd_ready) ready_bad++;
      end
      @(negedge clk);
    end
    e = rsp_valid ? rsp_err : 1'b1;
    q = rsp_data;
  endtask

  logic e;
  logic [7:0] q;
  int nb;

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_ready == 1'b1 && busy == 1'b0, "R1 idle after reset", {cmd_ready, busy}, 2'b10);
    chk(locked == 1'b0 && rsp_valid == 1'b0, "R1 unlocked no rsp", {locked, rsp_valid}, 0);
    do_cmd(3'd1, 4'd5, 8'h00, 1'b0, e, q, nb);
    chk(!e && q == 8'hFF && nb == 0, "R1 R3 erased word read", q, 8'hFF);
    do_cmd(3'd4, 4'd2, 8'h00, 1'b0, e, q, nb);
    chk(!e && q == 8'hFF, "R1 erased signature", q, 8'hFF);
  endtask

  task automatic t_prog_read();
    do_cmd(3'd0, 4'd3, 8'hA5, 1'b0, e, q, nb);
    chk(!e && nb == BC, "R4 write busy length", nb, BC);
    chk(ready_bad == 0, "R2 ready low while busy", ready_bad, 0);
    do_cmd(3'd0, 4'd15, 8'h3C, 1'b0, e, q, nb);
    do_cmd(3'd1, 4'd3, 8'h00, 1'b0, e, q, nb);
    chk(!e && q == 8'hA5, "R3 R4 read back word 3", q, 8'hA5);
    do_cmd(3'd1, 4'd15, 8'h00, 1'b0, e, q, nb);
    chk(!e && q == 8'h3C, "R3 R4 read back word 15", q, 8'h3C);
    do_cmd(3'd1, 4'd0, 8'h00, 1'b0, e, q, nb);
    chk(!e && q == 8'hFF, "R4 other word untouched", q, 8'hFF);
  endtask

  task automatic t_signature();
    do_cmd(3'd5, 4'd0, 8'h12, 1'b0, e, q, nb);
    chk(!e && nb == BC, "R10 signature write busy", nb, BC);
    do_cmd(3'd5, 4'd1, 8'h34, 1'b0, e, q, nb);
    do_cmd(3'd5, 4'd2, 8'h56, 1'b0, e, q, nb);
    do_cmd(3'd4, 4'd1, 8'h00, 1'b0, e, q, nb);
    chk(!e && q == 8'h34, "R9 R10 signature chunk 1", q, 8'h34);
    do_cmd(3'd4, 4'd2, 8'h00, 1'b0, e, q, nb);
    chk(!e && q == 8'h56, "R9 R10 signature chunk 2", q, 8'h56);
    do_cmd(3'd4, 4'd3, 8'h00, 1'b0, e, q, nb);
    chk(e && q == 8'h00, "R11 chunk index out of range", {e, q}, 9'h100);
    do_cmd(3'd5, 4'd3, 8'h77, 1'b0, e, q, nb);
    chk(e && nb == 0, "R11 signature write out of range", {e, nb[7:0]}, 9'h100);
    do_cmd(3'd6, 4'd0, 8'h00, 1'b0, e, q, nb);
    chk(e && q == 8'h00 && nb == 0, "R11 opcode 6 refused", {e, q}, 9'h100);
    do_cmd(3'd7, 4'd0, 8'h00, 1'b0, e, q, nb);
    chk(e && q == 8'h00, "R11 opcode 7 refused", {e, q}, 9'h100);
  endtask

  task automatic t_lock();
    do_cmd(3'd2, 4'd0, 8'h00, 1'b0, e, q, nb);
    chk(!e && nb == BC && locked, "R5 lock command", {locked, nb[7:0]}, {1'b1, 8'(BC)});
    do_cmd(3'd1, 4'd3, 8'h00, 1'b0, e, q, nb);
    chk(e && q == 8'h00 && nb == 0, "R7 read refused when locked", {e, q}, 9'h100);
    do_cmd(3'd0, 4'd3, 8'h11, 1'b0, e, q, nb);
    chk(e && nb == 0, "R7 write refused when locked", {e, nb[7:0]}, 9'h100);
    do_cmd(3'd5, 4'd0, 8'h99, 1'b0, e, q, nb);
    chk(e && nb == 0, "R7 signature write refused when locked", {e, nb[7:0]}, 9'h100);
    do_cmd(3'd4, 4'd1, 8'h00, 1'b0, e, q, nb);
    chk(!e && q == 8'h34, "R9 signature readable when locked", q, 8'h34);
    do_cmd(3'd4, 4'd0, 8'h00, 1'b0, e, q, nb);
    chk(!e && q == 8'h12, "R7 signature chunk 0 kept", q, 8'h12);
    do_cmd(3'd2, 4'd0, 8'h00, 1'b0, e, q, nb);
    chk(!e && locked, "R12 relock accepted", {e, locked}, 2'b01);
  endtask

  task automatic t_erase();
    do_cmd(3'd3, 4'd0, 8'h00, 1'b0, e, q, nb);
    chk(!e && nb == BC && !locked, "R8 erase unlocks", {locked, nb[7:0]}, BC);
    do_cmd(3'd1, 4'd3, 8'h00, 1'b0, e, q, nb);
    chk(!e && q == 8'hFF, "R8 pattern erased", q, 8'hFF);
    do_cmd(3'd4, 4'd0, 8'h00, 1'b0, e, q, nb);
    chk(!e && q == 8'hFF, "R8 signature erased", q, 8'hFF);
  endtask

  task automatic t_seal();
    do_cmd(3'd0, 4'd7, 8'h5A, 1'b0, e, q, nb);
    do_cmd(3'd0, 4'd8, 8'hC3, 1'b1, e, q, nb);
    chk(!e && nb == BC && locked, "R6 sealed write locks", {locked, nb[7:0]}, {1'b1, 8'(BC)});
    do_cmd(3'd1, 4'd7, 8'h00, 1'b0, e, q, nb);
    chk(e && q == 8'h00, "R6 R7 read refused after seal", {e, q}, 9'h100);
    do_cmd(3'd3, 4'd0, 8'h00, 1'b0, e, q, nb);
    do_cmd(3'd1, 4'd8, 8'h00, 1'b0, e, q, nb);
    chk(!e && q == 8'hFF && !locked, "R8 erase after seal", q, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_prog_read();
    t_signature();
    t_lock();
    t_erase();
    t_seal();
    chk(ready_bad == 0, "R2 ready low in every busy cycle", ready_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule